// File: doc/BRIEF.md
# Dual Multiply-Accumulate Long Reduction Engine

This block folds two 128-bit vectors into a 64-bit running sum. Each vector holds eight 16-bit lanes or four 32-bit lanes. The engine multiplies lane pairs and adds each product to the accumulator. Two options change this. A subtract option takes products at odd lanes away from the sum. An exchange option pairs each lane of the second vector with the neighbouring lane of the first vector. A 16-bit byte-granular predicate decides, lane by lane, whether a lane takes part.

A caller presents both vectors, a starting accumulator value, the predicate and the mode controls, then pulses `start`. The engine captures everything on that edge. It then works through one lane per clock. After the last lane it raises `done` for one cycle and presents the final sum on `result`. The result stays there until the next accepted start.

Top module: `dmac_reduce`

## Requirements
- R1: While reset is high and after it is released, `busy` and `done` are 0 and `result` is 0.
- R2: A `start` sampled while idle is accepted. `busy` then stays high while the lanes are processed. `done` is high for exactly one cycle, on the (N+1)th rising edge after the accepting edge, where N is 8 for 16-bit lanes and 4 for 32-bit lanes.
- R3: With `size_sel`=0 (16-bit lanes, lane e at bits 16e+15..16e), signed plain mode gives acc_in + sum of a[e]*b[e] over the active lanes.
- R4: With `size_sel`=1 (32-bit lanes, lane e at bits 32e+31..32e), the same sum is formed over four lanes.
- R5: With `is_signed`=0, lanes are zero-extended before multiplying. With `is_signed`=1, they are sign-extended.
- R6: With exchange set in signed mode, even lane e uses a[e+1]*b[e] and odd lane e uses a[e-1]*b[e].
- R7: With the subtract control set in signed mode, products of even lanes are added and products of odd lanes are subtracted.
- R8: Lane e contributes only when `pred` bit 2e (16-bit lanes) or bit 4e (32-bit lanes) is 1. The other predicate bits have no effect.
- R9: When `is_signed`=0, the exchange and subtract controls are ignored, and the result equals plain unsigned addition.
- R10: The sum wraps modulo 2^64 and sets no flag.
- R11: A `start` while `busy` is ignored and does not disturb the operation in progress. `result` holds its value while idle until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| size_sel | input | 1 | 0: 16-bit lanes, 1: 32-bit lanes |
| is_signed | input | 1 | 1: sign-extend lanes |
| exchange | input | 1 | Cross-pair adjacent lanes of the first vector |
| sub_odd | input | 1 | Subtract products of odd lanes |
| vec_a | input | 128 | First operand vector |
| vec_b | input | 128 | Second operand vector |
| pred | input | 16 | Byte predicate |
| acc_in | input | 64 | Starting accumulator value |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when `result` is final |
| result | output | 64 | Accumulated sum |

## Verification
The accumulator is updated in place, one lane per clock, so a wrong internal state cannot hide. A lane counter that skips or repeats a lane, a wrong partner index or a wrong sign choice changes the 64-bit `result` of the operation that is running. That error shows on the same cycle that `done` rises. A stuck or miscounted lane counter shifts the `done` pulse away from its fixed latency, and a counter that never reaches the end never raises `done` at all. A wrong hold or ignore path shows as a `result` that drifts in the idle cycles after `done`.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    localparam int VEC_W    = 128;
    localparam int ACC_W    = 64;
    localparam int NARROW_W = 16;
    localparam int WIDE_W   = 32;
    localparam int PRED_W   = VEC_W / 8;

    typedef enum logic {
        ESZ_HALF = 1'b0,
        ESZ_WORD = 1'b1
    } esize_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } state_e;

    typedef struct packed {
        esize_e esz;
        logic   sgn;
        logic   xch;
        logic   sub;
    } mode_t;

    // Exchange and odd-subtract only exist in signed operation.
    function automatic mode_t legalize(logic size_sel, logic sgn, logic xch, logic sub);
        mode_t m;
        m.esz = esize_e'(size_sel);
        m.sgn = sgn;
        m.xch = xch & sgn;
        m.sub = sub & sgn;
        return m;
    endfunction

    // Widen an element by one bit so a signed multiply serves both signednesses.
    function automatic logic [WIDE_W:0] widen(logic [WIDE_W-1:0] v, esize_e esz, logic sgn);
        logic [WIDE_W:0] r;
        if (esz == ESZ_WORD)
            r = {sgn & v[WIDE_W-1], v};
        else
            r = {{(WIDE_W-NARROW_W+1){sgn & v[NARROW_W-1]}}, v[NARROW_W-1:0]};
        return r;
    endfunction

endpackage

// File: rtl/dmac_ctrl.sv
module dmac_ctrl
    import dmac_pkg::*;
#(
    parameter int N_HALF = VEC_W / NARROW_W,
    parameter int N_WORD = VEC_W / WIDE_W,
    localparam int LANE_W = $clog2(N_HALF)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  esize_e            esz,
    output logic              accept,
    output logic              busy,
    output logic              done,
    output logic [LANE_W-1:0] lane
);

    state_e            state;
    logic [LANE_W-1:0] last_idx;
    logic              is_last;

    always_comb begin
        if (esz == ESZ_WORD)
            last_idx = LANE_W'(N_WORD - 1);
        else
            last_idx = LANE_W'(N_HALF - 1);
        is_last = (lane == last_idx);
        busy    = (state == ST_RUN);
        accept  = start && (state == ST_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            lane  <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state <= ST_RUN;
                        lane  <= '0;
                    end
                end
                ST_RUN: begin
                    lane <= lane + 1'b1;
                    if (is_last) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R2: done is a single-cycle pulse
    p_done_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R2: done only follows a running cycle
    p_done_after_run_r2: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    // R4: word lanes never index past the fourth lane
    p_lane_bound_r4: assert property (@(posedge clk) disable iff (rst)
        (busy && esz == ESZ_WORD) |-> (lane < LANE_W'(N_WORD)));

endmodule

// File: rtl/dmac_lane_sel.sv
module dmac_lane_sel
    import dmac_pkg::*;
#(
    parameter int N_HALF = VEC_W / NARROW_W,
    parameter int N_WORD = VEC_W / WIDE_W,
    localparam int LANE_W = $clog2(N_HALF),
    localparam int WIDX_W = $clog2(N_WORD),
    localparam int BPOS_W = $clog2(PRED_W)
) (
    input  logic [VEC_W-1:0]  vec_a,
    input  logic [VEC_W-1:0]  vec_b,
    input  logic [PRED_W-1:0] pred,
    input  mode_t             mode,
    input  logic [LANE_W-1:0] lane,
    output logic [WIDE_W:0]   op_a,
    output logic [WIDE_W:0]   op_b,
    output logic              active
);

    logic [NARROW_W-1:0] half_a [N_HALF];
    logic [NARROW_W-1:0] half_b [N_HALF];
    logic [WIDE_W-1:0]   word_a [N_WORD];
    logic [WIDE_W-1:0]   word_b [N_WORD];

    for (genvar g = 0; g < N_HALF; g++) begin : g_half
        assign half_a[g] = vec_a[g*NARROW_W +: NARROW_W];
        assign half_b[g] = vec_b[g*NARROW_W +: NARROW_W];
    end

    for (genvar g = 0; g < N_WORD; g++) begin : g_word
        assign word_a[g] = vec_a[g*WIDE_W +: WIDE_W];
        assign word_b[g] = vec_b[g*WIDE_W +: WIDE_W];
    end

    logic [LANE_W-1:0] idx_a;
    logic [WIDE_W-1:0] raw_a, raw_b;
    logic [BPOS_W-1:0] bpos;

    always_comb begin
        // Partner of lane e under exchange is e+1 for even e and e-1 for odd e.
        idx_a = mode.xch ? (lane ^ LANE_W'(1)) : lane;
        if (mode.esz == ESZ_WORD) begin
            raw_a = word_a[idx_a[WIDX_W-1:0]];
            raw_b = word_b[lane[WIDX_W-1:0]];
            bpos  = BPOS_W'({lane[WIDX_W-1:0], 2'b00});
        end else begin
            raw_a = {{(WIDE_W-NARROW_W){1'b0}}, half_a[idx_a]};
            raw_b = {{(WIDE_W-NARROW_W){1'b0}}, half_b[lane]};
            bpos  = BPOS_W'({lane, 1'b0});
        end
        op_a   = widen(raw_a, mode.esz, mode.sgn);
        op_b   = widen(raw_b, mode.esz, mode.sgn);
        active = pred[bpos];
    end

endmodule

// File: rtl/dmac_mul_acc.sv
module dmac_mul_acc
    import dmac_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [ACC_W-1:0] acc_init,
    input  logic             en,
    input  logic             active,
    input  logic             negate,
    input  logic [WIDE_W:0]  op_a,
    input  logic [WIDE_W:0]  op_b,
    output logic [ACC_W-1:0] acc
);

    localparam int PROD_W = 2 * (WIDE_W + 1);

    logic signed [PROD_W-1:0] prod;
    logic [ACC_W-1:0]         term;

    always_comb begin
        prod = PROD_W'($signed(op_a)) * PROD_W'($signed(op_b));
        term = prod[ACC_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
        end else if (load) begin
            acc <= acc_init;
        end else if (en && active) begin
            // Wraps modulo 2^ACC_W.
            if (negate)
                acc <= acc - term;
            else
                acc <= acc + term;
        end
    end

    // R8: a lane that is predicated off leaves the sum untouched
    p_masked_lane_r8: assert property (@(posedge clk) disable iff (rst)
        (en && !load && !active) |=> (acc == $past(acc)));

endmodule

// File: rtl/dmac_reduce.sv
module dmac_reduce
    import dmac_pkg::*;
#(
    parameter int N_HALF = VEC_W / NARROW_W,
    parameter int N_WORD = VEC_W / WIDE_W,
    localparam int LANE_W = $clog2(N_HALF)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              size_sel,
    input  logic              is_signed,
    input  logic              exchange,
    input  logic              sub_odd,
    input  logic [VEC_W-1:0]  vec_a,
    input  logic [VEC_W-1:0]  vec_b,
    input  logic [PRED_W-1:0] pred,
    input  logic [ACC_W-1:0]  acc_in,
    output logic              busy,
    output logic              done,
    output logic [ACC_W-1:0]  result
);

    mode_t             mode_q;
    logic [VEC_W-1:0]  a_q, b_q;
    logic [PRED_W-1:0] pred_q;
    logic              accept;
    logic [LANE_W-1:0] lane;
    logic [WIDE_W:0]   op_a, op_b;
    logic              active;
    logic              negate;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            a_q    <= '0;
            b_q    <= '0;
            pred_q <= '0;
        end else if (accept) begin
            mode_q <= legalize(size_sel, is_signed, exchange, sub_odd);
            a_q    <= vec_a;
            b_q    <= vec_b;
            pred_q <= pred;
        end
    end

    dmac_ctrl #(.N_HALF(N_HALF), .N_WORD(N_WORD)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .esz    (mode_q.esz),
        .accept (accept),
        .busy   (busy),
        .done   (done),
        .lane   (lane)
    );

    dmac_lane_sel #(.N_HALF(N_HALF), .N_WORD(N_WORD)) u_sel (
        .vec_a  (a_q),
        .vec_b  (b_q),
        .pred   (pred_q),
        .mode   (mode_q),
        .lane   (lane),
        .op_a   (op_a),
        .op_b   (op_b),
        .active (active)
    );

    assign negate = mode_q.sub & lane[0];

    dmac_mul_acc u_acc (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .acc_init (acc_in),
        .en       (busy),
        .active   (active),
        .negate   (negate),
        .op_a     (op_a),
        .op_b     (op_b),
        .acc      (result)
    );

    // R11: result holds while idle without a new start
    p_result_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(result));

    // R11: the captured configuration is frozen during a run
    p_cfg_frozen_r11: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(mode_q));

    // R9: unsigned operation never carries exchange or subtract
    p_unsigned_plain_r9: assert property (@(posedge clk) disable iff (rst)
        !mode_q.sgn |-> (!mode_q.xch && !mode_q.sub));

    // R2: busy and done never overlap
    p_busy_done_r2: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

endmodule

// File: tb/sim_dmac_reduce.sv
module sim_dmac_reduce;

    logic         clk = 1'b0;
    logic         rst;
    logic         start;
    logic         size_sel, is_signed, exchange, sub_odd;
    logic [127:0] vec_a, vec_b;
    logic [15:0]  pred;
    logic [63:0]  acc_in;
    logic         busy, done;
    logic [63:0]  result;

    int checks = 0;
    int errors = 0;
    logic [63:0] exp_q[$];
    string       tag_q[$];
    logic [63:0] last_exp;

    always #5 clk = ~clk;

    dmac_reduce u0 (
        .clk(clk), .rst(rst), .start(start), .size_sel(size_sel),
        .is_signed(is_signed), .exchange(exchange), .sub_odd(sub_odd),
        .vec_a(vec_a), .vec_b(vec_b), .pred(pred), .acc_in(acc_in),
        .busy(busy), .done(done), .result(result)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] elem(logic [127:0] v, int idx, int w, bit sgn);
        logic [63:0] x;
        logic [63:0] msk;
        msk = (w == 32) ? 64'h0000_0000_FFFF_FFFF : 64'h0000_0000_0000_FFFF;
        x = (v >> (idx * w)) & {64'h0, msk};
        if (sgn && x[w-1]) x = x | ~msk;
        return x;
    endfunction

    function automatic logic [63:0] model(logic [127:0] a, logic [127:0] b, logic [63:0] acc,
                                          logic [15:0] p, bit s32, bit sgn, bit xch, bit sub);
        int w = s32 ? 32 : 16;
        int n = s32 ? 4 : 8;
        bit ux = xch && sgn;
        bit us = sub && sgn;
        logic [63:0] s = acc;
        for (int e = 0; e < n; e++) begin
            int pa;
            logic [63:0] prd;
            if (p[e * (w / 8)]) begin
                pa = e;
                if (ux) pa = (e % 2 == 0) ? e + 1 : e - 1;
                prd = elem(a, pa, w, sgn) * elem(b, e, w, sgn);
                if (us && (e % 2 == 1)) s = s - prd;
                else s = s + prd;
            end
        end
        return s;
    endfunction

    // Monitor: pops the scoreboard on every done pulse.
    always @(negedge clk) begin
        if (!rst && done) begin
            if (exp_q.size() == 0) begin
                check("R11 unexpected done", result, 64'hx);
            end else begin
                logic [63:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, result, e);
            end
        end
    end

    task automatic run_op(string tag, bit s32, bit sgn, bit xch, bit sub,
                          logic [127:0] a, logic [127:0] b, logic [15:0] p, logic [63:0] acc);
        int lat;
        int n = s32 ? 4 : 8;
        @(negedge clk);
        size_sel = s32; is_signed = sgn; exchange = xch; sub_odd = sub;
        vec_a = a; vec_b = b; pred = p; acc_in = acc; start = 1'b1;
        last_exp = model(a, b, acc, p, s32, sgn, xch, sub);
        exp_q.push_back(last_exp);
        tag_q.push_back(tag);
        lat = 0;
        do begin
            @(negedge clk);
            start = 1'b0;
            lat++;
        end while (!done && lat < 40);
        check("R2 latency", 64'(lat), 64'(n + 1));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [127:0] va, vb;
        rst = 1'b1; start = 1'b0; size_sel = 0; is_signed = 0; exchange = 0; sub_odd = 0;
        vec_a = '0; vec_b = '0; pred = '0; acc_in = '0;
        repeat (3) @(negedge clk);
        check("R1 busy", 64'(busy), 64'd0);
        check("R1 done", 64'(done), 64'd0);
        check("R1 result", result, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 result after release", result, 64'd0);

        va = {16'd8, 16'd7, 16'd6, 16'd5, 16'hFFFD, 16'd3, 16'd2, 16'd1};
        vb = {16'd1, 16'd2, 16'd3, 16'd4, 16'd5, 16'hFFFE, 16'd7, 16'd8};
        run_op("R3 signed half plain", 0, 1, 0, 0, va, vb, 16'hFFFF, 64'd100);
        run_op("R5 unsigned half", 0, 0, 0, 0, va, vb, 16'hFFFF, 64'd0);
        run_op("R6 exchange half", 0, 1, 1, 0, va, vb, 16'hFFFF, 64'd0);
        run_op("R7 subtract half", 0, 1, 0, 1, va, vb, 16'hFFFF, 64'd0);
        run_op("R7 R6 exchange subtract half", 0, 1, 1, 1, va, vb, 16'hFFFF, 64'd5);
        run_op("R8 predicate half", 0, 1, 0, 0, va, vb, 16'b0000_0100_0001_0001, 64'd0);
        run_op("R8 odd bits only", 0, 1, 0, 0, va, vb, 16'hAAAA, 64'h1234);
        run_op("R9 unsigned ignores modes", 0, 0, 1, 1, va, vb, 16'hFFFF, 64'd0);

        va = {32'h8000_0000, 32'd70000, 32'hFFFF_FFFF, 32'd12345};
        vb = {32'h7FFF_FFFF, 32'd3, 32'hFFFF_FFFF, 32'd10};
        run_op("R4 signed word plain", 1, 1, 0, 0, va, vb, 16'hFFFF, 64'd0);
        run_op("R5 unsigned word", 1, 0, 0, 0, va, vb, 16'hFFFF, 64'd0);
        run_op("R6 exchange word", 1, 1, 1, 0, va, vb, 16'hFFFF, 64'd0);
        run_op("R7 subtract word", 1, 1, 0, 1, va, vb, 16'hFFFF, 64'd0);
        run_op("R8 predicate word", 1, 1, 0, 0, va, vb, 16'b0001_0000_0001_0000, 64'd7);
        run_op("R8 non-lane bits word", 1, 1, 0, 0, va, vb, 16'hEEEE, 64'd9);
        run_op("R9 unsigned word ignores modes", 1, 0, 1, 1, va, vb, 16'hFFFF, 64'd1);

        va = {4{32'hFFFF_FFFF}};
        run_op("R10 wrap", 1, 0, 0, 0, va, va, 16'hFFFF, 64'hFFFF_FFFF_FFFF_FFF0);

        for (int i = 0; i < 24; i++) begin
            va = {$urandom, $urandom, $urandom, $urandom};
            vb = {$urandom, $urandom, $urandom, $urandom};
            run_op("R3 R4 R6 R7 R8 mixed", i[0], i[1], i[2], i[3], va, vb,
                   16'($urandom), {$urandom, $urandom});
        end

        // R11: a second start during a run is ignored
        @(negedge clk);
        va = {8{16'd3}}; vb = {8{16'd4}};
        size_sel = 0; is_signed = 1; exchange = 0; sub_odd = 0;
        vec_a = va; vec_b = vb; pred = 16'hFFFF; acc_in = 64'd0; start = 1'b1;
        last_exp = model(va, vb, 64'd0, 16'hFFFF, 0, 1, 0, 0);
        exp_q.push_back(last_exp);
        tag_q.push_back("R11 start while busy");
        @(negedge clk); start = 1'b0;
        @(negedge clk);
        acc_in = 64'hDEAD; vec_a = '1; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (12) @(negedge clk);
        check("R11 queue drained", 64'(exp_q.size()), 64'd0);

        // R11: result holds while idle with changing inputs
        acc_in = 64'h5555; vec_b = '1; pred = 16'h0;
        repeat (4) @(negedge clk);
        check("R11 result hold", result, last_exp);
        check("R11 busy idle", 64'(busy), 64'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule